// File: doc/BRIEF.md
# Decode-Stage Next-PC Unit With One Delay Slot

This block owns the program counter and the fetch/decode pipeline register of a five-stage 32-bit pipeline. It resolves every change of control flow in the decode stage. Conditional branches compare two register operands that the forwarding logic has already corrected. Direct jumps take their target from the instruction word. A register jump takes its target from the corrected first operand. The block then steers the next fetch address through a four-way selector.

The pipeline has exactly one delay slot. The instruction fetched while a branch or jump sits in decode is always latched into the decode register on the next edge, and it is never cancelled, whether or not the branch is taken. A stall input freezes both the PC and the decode register. This lets the instruction in decode be presented again after a load-use hazard.

The instruction memory drives `fetch_inst` from `pc`. The register file and the forwarding selection sit outside the block and supply `fwd_a` (the rs value) and `fwd_b` (the rt value) for the instruction held in `id_inst`. Instruction fields: opcode in bits 31:26, function code in bits 5:0, immediate in bits 15:0, jump field in bits 25:0.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc`, `id_inst` and `id_pc4` are all zero.
- R2: When `stall` is low and decode holds no control instruction, `pc_sel` is 2'b00 and `next_pc` equals `pc`+4. At each rising edge the PC loads `next_pc`, `id_inst` loads `fetch_inst`, and `id_pc4` loads the old `pc`+4.
- R3: `ops_equal` is 1 exactly when all 32 bits of `fwd_a` and `fwd_b` match. A single differing bit, at any position, clears it.
- R4: For opcode 6'b000100 (branch-if-equal), when the operands are equal, `pc_sel` is 2'b01 and `next_pc` = `id_pc4` + (sign-extended immediate << 2). When they differ, `pc_sel` is 2'b00.
- R5: For opcode 6'b000101 (branch-if-not-equal), when the operands differ, `pc_sel` is 2'b01 with the same target as R4. When they are equal, `pc_sel` is 2'b00.
- R6: For opcodes 6'b000010 (jump) and 6'b000011 (jump-and-link), `pc_sel` is 2'b11 and `next_pc` = {`id_pc4`[31:28], jump field, 2'b00}.
- R7: For opcode 6'b000000 with function code 6'b001000 (register jump), `pc_sel` is 2'b10 and `next_pc` equals `fwd_a`.
- R8: The instruction fetched while a branch or jump is in decode enters `id_inst` on the next unstalled edge, whether or not the branch is taken, and in the same edge `pc` takes the selected target.
- R9: While `stall` is high, `pc`, `id_inst` and `id_pc4` keep their values across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Load-use stall; high holds PC and decode register |
| fetch_inst | input | 32 | Instruction read at `pc` |
| fwd_a | input | 32 | Forwarded rs operand of the decode instruction |
| fwd_b | input | 32 | Forwarded rt operand of the decode instruction |
| pc | output | 32 | Current fetch address |
| id_inst | output | 32 | Instruction held in the decode register |
| id_pc4 | output | 32 | Address after the decode instruction |
| next_pc | output | 32 | Selected next fetch address |
| pc_sel | output | 2 | Next-PC source: 00 seq, 01 branch, 10 register, 11 jump |
| ops_equal | output | 1 | Operand equality flag |

## Verification
The properties assume that `fwd_a` and `fwd_b` already belong to the instruction in `id_inst` and stay steady through the cycle. They also assume that `stall` changes only between edges. The bench therefore drives operands, `stall` and `fetch_inst` only on the falling edge, after the decode register has settled. It keeps each control instruction and its operands in place until the edge that consumes the selection. Operands that differ are made to differ in a single bit, at the top or bottom position, so that the equality path is tested at its edges.

// File: rtl/npc_pkg.sv
package npc_pkg;
   localparam int OP_W = 6;
   localparam int FN_W = 6;

   localparam logic [OP_W-1:0] OPC_SPECIAL = 6'b000000;
   localparam logic [OP_W-1:0] OPC_J       = 6'b000010;
   localparam logic [OP_W-1:0] OPC_JAL     = 6'b000011;
   localparam logic [OP_W-1:0] OPC_BEQ     = 6'b000100;
   localparam logic [OP_W-1:0] OPC_BNE     = 6'b000101;
   localparam logic [FN_W-1:0] FN_JR       = 6'b001000;

   typedef enum logic [1:0] {
      SEL_SEQ = 2'b00,
      SEL_BR  = 2'b01,
      SEL_REG = 2'b10,
      SEL_JMP = 2'b11
   } pc_sel_e;
endpackage

// File: rtl/npc_eq.sv
// Lane-split equality: each lane is a NOR over XOR, lanes are ANDed.
module npc_eq #(
   parameter int XLEN   = 32,
   parameter int LANE_W = 8
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            eq
);
   localparam int LANES = XLEN / LANE_W;

   if ((XLEN % LANE_W) != 0) begin : g_bad_lane
      $error("npc_eq: XLEN must be a multiple of LANE_W");
   end

   logic [LANES-1:0] lane_eq;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_eq[g] = ~|(a[g*LANE_W +: LANE_W] ^ b[g*LANE_W +: LANE_W]);
   end

   assign eq = &lane_eq;
endmodule

// File: rtl/npc_ctrl.sv
module npc_ctrl
   import npc_pkg::*;
(
   input  logic [OP_W-1:0] op,
   input  logic [FN_W-1:0] fn,
   input  logic            eq,
   output pc_sel_e         sel
);
   always_comb begin
      sel = SEL_SEQ;
      unique case (op)
         OPC_BEQ:     sel = eq ? SEL_BR : SEL_SEQ;
         OPC_BNE:     sel = eq ? SEL_SEQ : SEL_BR;
         OPC_J,
         OPC_JAL:     sel = SEL_JMP;
         OPC_SPECIAL: sel = (fn == FN_JR) ? SEL_REG : SEL_SEQ;
         default:     sel = SEL_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16,
   parameter int JF_W  = 26
) (
   input  logic [XLEN-1:0]  pc4,
   input  logic [IMM_W-1:0] imm,
   input  logic [JF_W-1:0]  jfield,
   output logic [XLEN-1:0]  br_tgt,
   output logic [XLEN-1:0]  jmp_tgt
);
   localparam int SHIFT = 2;
   localparam int EXT_W = XLEN - IMM_W - SHIFT;
   localparam int HI_W  = XLEN - JF_W - SHIFT;

   if (EXT_W < 0 || HI_W < 1) begin : g_bad_geom
      $error("npc_target: field widths do not fit XLEN");
   end

   logic [XLEN-1:0] offset;

   assign offset  = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
   assign br_tgt  = pc4 + offset;
   assign jmp_tgt = {pc4[XLEN-1 -: HI_W], jfield, {SHIFT{1'b0}}};
endmodule

// File: rtl/npc_mux.sv
module npc_mux
   import npc_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter bit ONEHOT = 1'b0
) (
   input  pc_sel_e         sel,
   input  logic [XLEN-1:0] in_seq,
   input  logic [XLEN-1:0] in_br,
   input  logic [XLEN-1:0] in_reg,
   input  logic [XLEN-1:0] in_jmp,
   output logic [XLEN-1:0] y
);
   if (ONEHOT) begin : g_andor
      logic [3:0] hot;
      assign hot = 4'b0001 << sel;
      assign y = ({XLEN{hot[0]}} & in_seq) | ({XLEN{hot[1]}} & in_br)
               | ({XLEN{hot[2]}} & in_reg) | ({XLEN{hot[3]}} & in_jmp);
   end else begin : g_case
      always_comb begin
         unique case (sel)
            SEL_SEQ: y = in_seq;
            SEL_BR:  y = in_br;
            SEL_REG: y = in_reg;
            SEL_JMP: y = in_jmp;
            default: y = in_seq;
         endcase
      end
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              IMM_W      = 16,
   parameter int              JF_W       = 26,
   parameter int              EQ_LANE_W  = 8,
   parameter bit              MUX_ONEHOT = 1'b0,
   parameter logic [XLEN-1:0] RESET_PC   = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stall,
   input  logic [XLEN-1:0] fetch_inst,
   input  logic [XLEN-1:0] fwd_a,
   input  logic [XLEN-1:0] fwd_b,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] id_inst,
   output logic [XLEN-1:0] id_pc4,
   output logic [XLEN-1:0] next_pc,
   output logic [1:0]      pc_sel,
   output logic            ops_equal
);
   localparam logic [XLEN-1:0] INST_BYTES = XLEN'(4);

   if (XLEN != OP_W + JF_W) begin : g_bad_word
      $error("npc_unit: opcode plus jump field must fill the word");
   end
   if (IMM_W > JF_W) begin : g_bad_imm
      $error("npc_unit: immediate cannot exceed the jump field");
   end

   logic [XLEN-1:0] pc4;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] jmp_tgt;
   pc_sel_e         sel;

   assign pc4 = pc + INST_BYTES;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc      <= RESET_PC;
         id_inst <= '0;
         id_pc4  <= '0;
      end else if (!stall) begin
         pc      <= next_pc;
         id_inst <= fetch_inst;
         id_pc4  <= pc4;
      end
   end

   npc_eq #(.XLEN(XLEN), .LANE_W(EQ_LANE_W)) u_eq (
      .a  (fwd_a),
      .b  (fwd_b),
      .eq (ops_equal)
   );

   npc_ctrl u_ctrl (
      .op  (id_inst[XLEN-1 -: OP_W]),
      .fn  (id_inst[FN_W-1:0]),
      .eq  (ops_equal),
      .sel (sel)
   );

   npc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JF_W(JF_W)) u_tgt (
      .pc4     (id_pc4),
      .imm     (id_inst[IMM_W-1:0]),
      .jfield  (id_inst[JF_W-1:0]),
      .br_tgt  (br_tgt),
      .jmp_tgt (jmp_tgt)
   );

   npc_mux #(.XLEN(XLEN), .ONEHOT(MUX_ONEHOT)) u_mux (
      .sel    (sel),
      .in_seq (pc4),
      .in_br  (br_tgt),
      .in_reg (fwd_a),
      .in_jmp (jmp_tgt),
      .y      (next_pc)
   );

   assign pc_sel = sel;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            stall,
   input logic [XLEN-1:0] fetch_inst,
   input logic [XLEN-1:0] fwd_a,
   input logic [XLEN-1:0] fwd_b,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] id_inst,
   input logic [XLEN-1:0] id_pc4,
   input logic [XLEN-1:0] next_pc,
   input logic [1:0]      pc_sel,
   input logic            ops_equal
);
   logic [5:0] op;
   logic [5:0] fn;
   assign op = id_inst[XLEN-1 -: 6];
   assign fn = id_inst[5:0];

   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         p_reset_state_r1: assert (pc == '0 && id_inst == '0 && id_pc4 == '0);
      end
   end

   p_pc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> pc == $past(next_pc));

   p_eq_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ops_equal == (fwd_a == fwd_b));

   p_beq_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 6'b000100 && fwd_a == fwd_b) |-> pc_sel == 2'b01);

   p_bne_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 6'b000101 && fwd_a != fwd_b) |-> pc_sel == 2'b01);

   p_jump_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 6'b000010 || op == 6'b000011) |-> pc_sel == 2'b11);

   p_jr_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 6'b000000 && fn == 6'b001000) |-> (pc_sel == 2'b10 && next_pc == fwd_a));

   p_slot_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> id_inst == $past(fetch_inst));

   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(pc) && $stable(id_inst) && $stable(id_pc4)));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_npc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stall      (stall),
   .fetch_inst (fetch_inst),
   .fwd_a      (fwd_a),
   .fwd_b      (fwd_b),
   .pc         (pc),
   .id_inst    (id_inst),
   .id_pc4     (id_pc4),
   .next_pc    (next_pc),
   .pc_sel     (pc_sel),
   .ops_equal  (ops_equal)
);

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall = 1'b0;
   logic [31:0] fetch_inst = '0;
   logic [31:0] fwd_a = '0;
   logic [31:0] fwd_b = '0;
   logic [31:0] pc, id_inst, id_pc4, next_pc;
   logic [1:0]  pc_sel;
   logic        ops_equal;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   npc_unit dut (
      .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_inst(fetch_inst),
      .fwd_a(fwd_a), .fwd_b(fwd_b), .pc(pc), .id_inst(id_inst),
      .id_pc4(id_pc4), .next_pc(next_pc), .pc_sel(pc_sel), .ops_equal(ops_equal)
   );

   function automatic logic [31:0] enc_i(logic [5:0] op, logic [15:0] imm);
      return {op, 5'd4, 5'd5, imm};
   endfunction
   function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] fld);
      return {op, fld};
   endfunction
   function automatic logic [31:0] sext4(logic [15:0] imm);
      return {{14{imm[15]}}, imm, 2'b00};
   endfunction

   localparam logic [31:0] I_ADD = 32'h01094020;
   localparam logic [31:0] I_JR  = 32'h03E00008;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at the falling edge, let one rising edge pass, return at the next fall
   task automatic step(logic [31:0] inst);
      fetch_inst = inst;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 pc", pc, 32'h0);
      chk("R1 id_inst", id_inst, 32'h0);
      chk("R1 id_pc4", id_pc4, 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic t_sequential();
      logic [31:0] p0;
      p0 = pc;
      chk("R2 sel nop", {30'd0, pc_sel}, 32'd0);
      chk("R2 next nop", next_pc, p0 + 4);
      step(I_ADD);
      chk("R2 pc", pc, p0 + 4);
      chk("R2 id_inst", id_inst, I_ADD);
      chk("R2 id_pc4", id_pc4, p0 + 4);
      chk("R2 sel add", {30'd0, pc_sel}, 32'd0);
   endtask

   task automatic t_equality();
      fwd_a = 32'h1234_5678; fwd_b = 32'h1234_5678; #1;
      chk("R3 equal", {31'd0, ops_equal}, 32'd1);
      fwd_b = 32'h9234_5678; #1;
      chk("R3 msb differs", {31'd0, ops_equal}, 32'd0);
      fwd_b = 32'h1234_5679; #1;
      chk("R3 lsb differs", {31'd0, ops_equal}, 32'd0);
      fwd_a = '0; fwd_b = '0;
   endtask

   task automatic t_beq();
      fwd_a = 32'hCAFE_0001; fwd_b = 32'hCAFE_0001;
      step(enc_i(6'b000100, 16'h0003));
      chk("R4 beq eq sel", {30'd0, pc_sel}, 32'd1);
      chk("R4 beq fwd tgt", next_pc, id_pc4 + 32'd12);
      step(enc_i(6'b000100, 16'hFFFC));
      chk("R4 beq back tgt", next_pc, id_pc4 - 32'd16);
      fwd_b = 32'hCAFE_0000;
      step(enc_i(6'b000100, 16'h0003));
      chk("R4 beq ne sel", {30'd0, pc_sel}, 32'd0);
      chk("R4 beq ne next", next_pc, pc + 4);
   endtask

   task automatic t_bne();
      fwd_a = 32'h0000_0005; fwd_b = 32'h8000_0005;
      step(enc_i(6'b000101, 16'hFFFC));
      chk("R5 bne ne sel", {30'd0, pc_sel}, 32'd1);
      chk("R5 bne tgt", next_pc, id_pc4 + sext4(16'hFFFC));
      fwd_b = 32'h0000_0005;
      step(enc_i(6'b000101, 16'hFFFC));
      chk("R5 bne eq sel", {30'd0, pc_sel}, 32'd0);
      chk("R5 bne eq next", next_pc, pc + 4);
   endtask

   task automatic t_jr_and_jumps();
      fwd_a = 32'hA000_0010; fwd_b = 32'h0;
      step(I_JR);
      chk("R7 jr sel", {30'd0, pc_sel}, 32'd2);
      chk("R7 jr next", next_pc, 32'hA000_0010);
      step(I_ADD);
      chk("R8 jr slot kept", id_inst, I_ADD);
      chk("R8 jr pc", pc, 32'hA000_0010);
      step(enc_j(6'b000010, 26'h000001B));
      chk("R6 j sel", {30'd0, pc_sel}, 32'd3);
      chk("R6 j tgt", next_pc, 32'hA000_006C);
      step(enc_j(6'b000011, 26'h3FFFFFF));
      chk("R6 jal sel", {30'd0, pc_sel}, 32'd3);
      chk("R6 jal tgt", next_pc, 32'hAFFF_FFFC);
   endtask

   task automatic t_delay_slot();
      logic [31:0] tgt;
      fwd_a = 32'h77; fwd_b = 32'h77;
      step(enc_i(6'b000100, 16'h0005));
      tgt = id_pc4 + 32'd20;
      step(32'h2005_0004);
      chk("R8 taken slot", id_inst, 32'h2005_0004);
      chk("R8 taken pc", pc, tgt);
      fwd_b = 32'h76;
      step(enc_i(6'b000100, 16'h0005));
      tgt = pc + 4;
      step(32'h2005_0003);
      chk("R8 untaken slot", id_inst, 32'h2005_0003);
      chk("R8 untaken pc", pc, tgt);
   endtask

   task automatic t_stall();
      logic [31:0] p0, i0, d0;
      step(I_ADD);
      p0 = pc; i0 = id_inst; d0 = id_pc4;
      stall = 1'b1;
      step(32'hFFFF_FFFF);
      chk("R9 pc held", pc, p0);
      chk("R9 inst held", id_inst, i0);
      chk("R9 pc4 held", id_pc4, d0);
      stall = 1'b0;
      step(32'h1111_1111);
      chk("R9 resume", id_inst, 32'h1111_1111);
   endtask

   initial begin
      t_reset();
      t_sequential();
      t_equality();
      t_beq();
      t_bne();
      t_jr_and_jumps();
      t_delay_slot();
      t_stall();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule